// File: doc/BRIEF.md
# Least-attained-service memory request scheduler

This block picks, each cycle, which entry of a per-channel DRAM request queue is issued next. Every hardware thread is ranked by how much memory service it has received. The thread that has received the least service gets the highest rank, so its requests are preferred. Service is measured as bank-busy cycles. Each bank reports every cycle which thread, if any, it is serving. Those cycles are summed per thread over a fixed-length quantum.

At the end of each quantum, the per-thread sums are folded into exponentially smoothed totals, and the thread ranks are recomputed from those totals. The ranks stay fixed for the whole of the next quantum. A request that has waited longer than a starvation limit overrides the rank order. Within a rank, requests to an open row and older requests are preferred. DRAM timing checks, command generation and refresh are handled elsewhere. The picker only returns the queue index of the chosen entry.

Top module: `las_sched`

## Requirements
- R1: `grant_valid` is 1 in a cycle exactly when at least one queue entry has both `req_valid` and `req_ready` set. The selection is combinational from the current inputs and the rank state.
- R2: On every clock edge outside reset, each bank with `bank_busy` set adds one to the current-quantum count of the thread given in its `bank_thread` field.
- R3: The quantum lasts `QUANTUM` cycles. On the last edge of a quantum, each thread's total becomes T − (T>>3) + C and its count is cleared. T is the total in fixed point with 3 fraction bits, and C is the count including that edge's increments, so the weights are 7/8 old and 1/8 new. Totals change on no other edge.
- R4: A thread with a smaller total gets a better rank (rank 0 is best). Equal totals are ordered by the lower thread ID.
- R5: After reset, every thread's rank equals its thread ID. Newly computed ranks take effect one edge after the edge that updates the totals. Until then, the previous ranks stay in use.
- R6: An eligible entry whose `req_age` is greater than `STARVE` beats every entry that is not over the limit. Among such entries the largest age wins, and on equal ages the lower queue index wins.
- R7: Among eligible entries that are not over the limit, the order is: better thread rank first, then a row hit, then larger age, then lower queue index. A row hit means `bank_open` is set for the entry's bank and `bank_open_row` of that bank equals `req_row`.
- R8: An entry with `req_valid` or `req_ready` low is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NQ | Entry holds a request |
| req_ready | input | NQ | Entry can issue this cycle |
| req_thread | input | NQ*TW | Thread ID per entry |
| req_bank | input | NQ*BW | Bank per entry |
| req_row | input | NQ*ROW_W | Row per entry |
| req_age | input | NQ*AGE_W | Cycles waited per entry |
| bank_open | input | NBANK | Bank has an open row |
| bank_open_row | input | NBANK*ROW_W | Open row per bank |
| bank_busy | input | NBANK | Bank is serving a thread this cycle |
| bank_thread | input | NBANK*TW | Thread served per bank |
| grant_valid | output | 1 | A request is chosen |
| grant_idx | output | QW | Queue index of the chosen request |

## Verification
The reference model is driven with three kinds of traffic.

- Ages below the starvation limit with biased bank service. One thread dominates the busy banks for several quanta, and then another does. The rank order must flip at the predicted edge, which separates correct smoothing and rank timing from an off-by-one quantum or unweighted totals.
- Ages spread well above the limit. These show whether the override and its oldest-first order beat rank.
- Few rows and frequently open banks. These make row-hit ties common, so the row-hit and age tie-breaks within one rank decide the grant.

Sparse valid and ready masks run throughout, and they expose grants to ineligible entries.

// File: rtl/las_pkg.sv
package las_pkg;
  // Fraction bits of the smoothed totals; also the history weight 1 - 2^-SHIFT.
  localparam int unsigned SMOOTH_SHIFT = 3;
endpackage

// File: rtl/las_service_track.sv
module las_service_track
  import las_pkg::*;
#(
  parameter int unsigned NTHR    = 4,
  parameter int unsigned NBANK   = 4,
  parameter int unsigned QUANTUM = 10000000,
  localparam int unsigned TW     = $clog2(NTHR),
  localparam int unsigned QTW    = $clog2(QUANTUM),
  localparam int unsigned CNT_W  = $clog2(QUANTUM * NBANK + 1),
  localparam int unsigned TOT_W  = CNT_W + SMOOTH_SHIFT
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NBANK-1:0]        bank_busy,
  input  logic [NBANK*TW-1:0]     bank_thread,
  output logic [NTHR*TOT_W-1:0]   totals,
  output logic                    qend
);
  logic [QTW-1:0]   qcnt_q, qcnt_d;
  logic [CNT_W-1:0] cnt_q [NTHR];
  logic [CNT_W-1:0] cnt_d [NTHR];
  logic [CNT_W-1:0] sum   [NTHR];
  logic [TOT_W-1:0] tot_q [NTHR];
  logic [TOT_W-1:0] tot_d [NTHR];

  always_comb begin
    qend   = (qcnt_q == QTW'(QUANTUM - 1));
    qcnt_d = qend ? '0 : qcnt_q + 1'b1;
    for (int t = 0; t < NTHR; t++) begin
      sum[t] = cnt_q[t];
      for (int b = 0; b < NBANK; b++) begin
        if (bank_busy[b] && (bank_thread[b*TW +: TW] == TW'(t)))
          sum[t] = sum[t] + 1'b1;
      end
      cnt_d[t] = qend ? '0 : sum[t];
      tot_d[t] = qend ? (tot_q[t] - (tot_q[t] >> SMOOTH_SHIFT) + TOT_W'(sum[t]))
                      : tot_q[t];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qcnt_q <= '0;
      for (int t = 0; t < NTHR; t++) begin
        cnt_q[t] <= '0;
        tot_q[t] <= '0;
      end
    end else begin
      qcnt_q <= qcnt_d;
      for (int t = 0; t < NTHR; t++) begin
        cnt_q[t] <= cnt_d[t];
        tot_q[t] <= tot_d[t];
      end
    end
  end

  for (genvar g = 0; g < NTHR; g++) begin : g_out
    assign totals[g*TOT_W +: TOT_W] = tot_q[g];

    // Totals move only on the quantum's last edge.
    assert_total_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !qend |=> $stable(tot_q[g]));
    // A count cannot exceed one per bank per elapsed cycle of the quantum.
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_q[g]) <= int'(qcnt_q) * int'(NBANK));
  end
endmodule

// File: rtl/las_rank.sv
module las_rank #(
  parameter int unsigned NTHR  = 4,
  parameter int unsigned TOT_W = 29,
  localparam int unsigned TW   = $clog2(NTHR)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NTHR*TOT_W-1:0] totals,
  input  logic                  qend,
  output logic [NTHR*TW-1:0]    ranks
);
  logic          load_q;
  logic [TW-1:0] rank_q [NTHR];
  logic [TW-1:0] rank_d [NTHR];

  // Rank = number of threads that order ahead (smaller total, or equal and lower ID).
  always_comb begin
    for (int t = 0; t < NTHR; t++) begin
      rank_d[t] = '0;
      for (int u = 0; u < NTHR; u++) begin
        if ((totals[u*TOT_W +: TOT_W] < totals[t*TOT_W +: TOT_W]) ||
            ((totals[u*TOT_W +: TOT_W] == totals[t*TOT_W +: TOT_W]) && (u < t)))
          rank_d[t] = rank_d[t] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= 1'b0;
      for (int t = 0; t < NTHR; t++) rank_q[t] <= TW'(t);
    end else begin
      load_q <= qend;
      if (load_q) begin
        for (int t = 0; t < NTHR; t++) rank_q[t] <= rank_d[t];
      end
    end
  end

  for (genvar a = 0; a < NTHR; a++) begin : g_rank
    assign ranks[a*TW +: TW] = rank_q[a];

    assert_rank_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !load_q |=> $stable(rank_q[a]));
    for (genvar b = a + 1; b < NTHR; b++) begin : g_pair
      assert_rank_unique_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rank_q[a] != rank_q[b]);
    end
  end
endmodule

// File: rtl/las_pick.sv
module las_pick #(
  parameter int unsigned NQ     = 8,
  parameter int unsigned NTHR   = 4,
  parameter int unsigned NBANK  = 4,
  parameter int unsigned ROW_W  = 8,
  parameter int unsigned AGE_W  = 20,
  parameter int unsigned STARVE = 100000,
  localparam int unsigned TW    = $clog2(NTHR),
  localparam int unsigned BW    = $clog2(NBANK),
  localparam int unsigned QW    = $clog2(NQ),
  localparam int unsigned KW    = 3 + TW + AGE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NQ-1:0]         req_valid,
  input  logic [NQ-1:0]         req_ready,
  input  logic [NQ*TW-1:0]      req_thread,
  input  logic [NQ*BW-1:0]      req_bank,
  input  logic [NQ*ROW_W-1:0]   req_row,
  input  logic [NQ*AGE_W-1:0]   req_age,
  input  logic [NBANK-1:0]      bank_open,
  input  logic [NBANK*ROW_W-1:0] bank_open_row,
  input  logic [NTHR*TW-1:0]    ranks,
  output logic                  grant_valid,
  output logic [QW-1:0]         grant_idx
);
  logic [KW-1:0] key [NQ];
  logic [KW-1:0] best_key;
  logic [NQ-1:0] elig, starved;

  always_comb begin
    for (int i = 0; i < NQ; i++) begin
      logic [TW-1:0]    thr, prio;
      logic [BW-1:0]    bk;
      logic [AGE_W-1:0] age;
      logic             hit;
      thr        = req_thread[i*TW +: TW];
      bk         = req_bank[i*BW +: BW];
      age        = req_age[i*AGE_W +: AGE_W];
      prio       = TW'(NTHR - 1) - ranks[thr*TW +: TW];
      hit        = bank_open[bk] && (bank_open_row[bk*ROW_W +: ROW_W] == req_row[i*ROW_W +: ROW_W]);
      elig[i]    = req_valid[i] & req_ready[i];
      starved[i] = (age > AGE_W'(STARVE));
      key[i]     = starved[i] ? {elig[i], 1'b1, {TW{1'b0}}, 1'b0, age}
                              : {elig[i], 1'b0, prio, hit, age};
    end
    best_key  = '0;
    grant_idx = '0;
    for (int i = 0; i < NQ; i++) begin
      if (key[i] > best_key) begin
        best_key  = key[i];
        grant_idx = QW'(i);
      end
    end
    grant_valid = best_key[KW-1];
  end

  assert_grant_iff_any_R1: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid == (|(req_valid & req_ready)));
  assert_grant_eligible_R8: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (req_valid[grant_idx] && req_ready[grant_idx]));
  assert_starve_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(elig & starved)) |-> (req_age[grant_idx*AGE_W +: AGE_W] > AGE_W'(STARVE)));
endmodule

// File: rtl/las_sched.sv
module las_sched
  import las_pkg::*;
#(
  parameter int unsigned NQ      = 8,
  parameter int unsigned NTHR    = 4,
  parameter int unsigned NBANK   = 4,
  parameter int unsigned ROW_W   = 8,
  parameter int unsigned AGE_W   = 20,
  parameter int unsigned QUANTUM = 10000000,
  parameter int unsigned STARVE  = 100000,
  localparam int unsigned TW     = $clog2(NTHR),
  localparam int unsigned BW     = $clog2(NBANK),
  localparam int unsigned QW     = $clog2(NQ),
  localparam int unsigned TOT_W  = $clog2(QUANTUM * NBANK + 1) + SMOOTH_SHIFT
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NQ-1:0]          req_valid,
  input  logic [NQ-1:0]          req_ready,
  input  logic [NQ*TW-1:0]       req_thread,
  input  logic [NQ*BW-1:0]       req_bank,
  input  logic [NQ*ROW_W-1:0]    req_row,
  input  logic [NQ*AGE_W-1:0]    req_age,
  input  logic [NBANK-1:0]       bank_open,
  input  logic [NBANK*ROW_W-1:0] bank_open_row,
  input  logic [NBANK-1:0]       bank_busy,
  input  logic [NBANK*TW-1:0]    bank_thread,
  output logic                   grant_valid,
  output logic [QW-1:0]          grant_idx
);
  logic [NTHR*TOT_W-1:0] totals;
  logic                  qend;
  logic [NTHR*TW-1:0]    ranks;

  las_service_track #(.NTHR(NTHR), .NBANK(NBANK), .QUANTUM(QUANTUM)) u_track (
    .clk(clk), .rst_n(rst_n), .bank_busy(bank_busy), .bank_thread(bank_thread),
    .totals(totals), .qend(qend)
  );

  las_rank #(.NTHR(NTHR), .TOT_W(TOT_W)) u_rank (
    .clk(clk), .rst_n(rst_n), .totals(totals), .qend(qend), .ranks(ranks)
  );

  las_pick #(.NQ(NQ), .NTHR(NTHR), .NBANK(NBANK), .ROW_W(ROW_W),
             .AGE_W(AGE_W), .STARVE(STARVE)) u_pick (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_thread(req_thread), .req_bank(req_bank), .req_row(req_row),
    .req_age(req_age), .bank_open(bank_open), .bank_open_row(bank_open_row),
    .ranks(ranks), .grant_valid(grant_valid), .grant_idx(grant_idx)
  );
endmodule

// File: tb/tb_las_sched.sv
module tb_las_sched;
  localparam int NQ = 8, NTHR = 4, NBANK = 4, ROW_W = 4, AGE_W = 10;
  localparam int QUANTUM = 50, STARVE = 300;
  localparam int TW = 2, BW = 2, QW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NQ-1:0]          req_valid = '0, req_ready = '0;
  logic [NQ*TW-1:0]       req_thread = '0;
  logic [NQ*BW-1:0]       req_bank = '0;
  logic [NQ*ROW_W-1:0]    req_row = '0;
  logic [NQ*AGE_W-1:0]    req_age = '0;
  logic [NBANK-1:0]       bank_open = '0, bank_busy = '0;
  logic [NBANK*ROW_W-1:0] bank_open_row = '0;
  logic [NBANK*TW-1:0]    bank_thread = '0;
  logic                   grant_valid;
  logic [QW-1:0]          grant_idx;

  las_sched #(.NQ(NQ), .NTHR(NTHR), .NBANK(NBANK), .ROW_W(ROW_W), .AGE_W(AGE_W),
              .QUANTUM(QUANTUM), .STARVE(STARVE)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_thread(req_thread), .req_bank(req_bank), .req_row(req_row), .req_age(req_age),
    .bank_open(bank_open), .bank_open_row(bank_open_row), .bank_busy(bank_busy),
    .bank_thread(bank_thread), .grant_valid(grant_valid), .grant_idx(grant_idx)
  );

  always #2 clk = ~clk;

  // Reference state
  int m_cnt [NTHR];
  int m_tot [NTHR];
  int m_rank[NTHR];
  int m_qc;
  bit m_pend;
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < NTHR; t++) begin m_cnt[t] = 0; m_tot[t] = 0; m_rank[t] = t; end
      m_qc = 0; m_pend = 0;
    end else begin
      // R5: ranks load one edge after the totals change
      if (m_pend) begin
        for (int t = 0; t < NTHR; t++) begin
          m_rank[t] = 0;
          for (int u = 0; u < NTHR; u++)
            if (m_tot[u] < m_tot[t] || (m_tot[u] == m_tot[t] && u < t)) m_rank[t]++;
        end
      end
      // R2: busy banks credit their thread
      for (int b = 0; b < NBANK; b++)
        if (bank_busy[b]) m_cnt[int'(bank_thread[b*TW +: TW])]++;
      if (m_qc == QUANTUM - 1) begin
        for (int t = 0; t < NTHR; t++) begin   // R3
          m_tot[t] = m_tot[t] - (m_tot[t] >> 3) + m_cnt[t];
          m_cnt[t] = 0;
        end
        m_qc = 0; m_pend = 1;
      end else begin
        m_qc++; m_pend = 0;
      end
    end
  end

  task automatic check_grant();
    int  best = -1;
    bit  best_st = 0; int best_pr = 0; bit best_hit = 0; int best_age = 0;
    bit  st, hit, better;
    int  pr, age, b;
    string tag;
    for (int i = 0; i < NQ; i++) begin
      if (!(req_valid[i] && req_ready[i])) continue;
      age = int'(req_age[i*AGE_W +: AGE_W]);
      st  = age > STARVE;
      pr  = m_rank[int'(req_thread[i*TW +: TW])];
      b   = int'(req_bank[i*BW +: BW]);
      hit = bank_open[b] && (bank_open_row[b*ROW_W +: ROW_W] == req_row[i*ROW_W +: ROW_W]);
      if (best < 0) better = 1;
      else if (st != best_st) better = st;
      else if (st) better = age > best_age;
      else if (pr != best_pr) better = pr < best_pr;
      else if (hit != best_hit) better = hit;
      else better = age > best_age;
      if (better) begin
        best = i; best_st = st; best_pr = pr; best_hit = hit; best_age = age;
      end
    end
    if (best < 0) tag = "R1 R8";
    else if (best_st) tag = "R6";
    else tag = "R2 R3 R4 R5 R7";
    n_checks++;
    if (grant_valid !== (best >= 0) || (best >= 0 && int'(grant_idx) != best)) begin
      n_fail++;
      $display("FAIL %s: grant_valid=%0b idx=%0d expected valid=%0b idx=%0d",
               tag, grant_valid, grant_idx, best >= 0, best);
    end
  endtask

  // mode 0: low ages, heavy thread hot; mode 1: wide ages; mode 2: row-hit heavy
  task automatic drive(int mode, int hot);
    for (int i = 0; i < NQ; i++) begin
      req_valid[i] = ($urandom % 4) != 0;
      req_ready[i] = ($urandom % 3) != 0;
      req_thread[i*TW +: TW] = TW'($urandom);
      req_bank[i*BW +: BW]   = BW'($urandom);
      req_row[i*ROW_W +: ROW_W] = (mode == 2) ? ROW_W'($urandom % 2) : ROW_W'($urandom);
      req_age[i*AGE_W +: AGE_W] = (mode == 1) ? AGE_W'($urandom) : AGE_W'($urandom % 280);
    end
    for (int b = 0; b < NBANK; b++) begin
      bank_open[b] = (mode == 2) ? 1'b1 : (($urandom % 2) != 0);
      bank_open_row[b*ROW_W +: ROW_W] = (mode == 2) ? ROW_W'($urandom % 2) : ROW_W'($urandom);
      bank_busy[b] = ($urandom % 5) != 0;
      bank_thread[b*TW +: TW] = (($urandom % 4) != 0) ? TW'(hot) : TW'($urandom);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state, nothing requested
    n_checks++;
    if (grant_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: grant_valid=%0b during reset expected 0", grant_valid);
    end
    rst_n = 1'b1;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      check_grant();
      if (c < 1000)      drive(0, 0);
      else if (c < 1600) drive(0, 3);
      else if (c < 2200) drive(2, 1);
      else               drive(1, 2);
    end
    @(negedge clk);
    check_grant();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule